// File: doc/BRIEF.md
# Multidrop Address and Control Character Filter

This block follows a serial character receiver and decides which received characters reach the buffer logic behind it. Each character arrives with a flag marking it as an address character. A separate pulse reports each idle character time seen on the line. In multidrop operation a station sleeps until it is addressed. It wakes either on a matching address character or on an idle line, depending on a configuration bit. While awake, the filter compares every character against eight programmable control characters. It also watches for idle timeouts and for new addresses, and from these it marks where each message ends.

The block also keeps four 16-bit error counters that saturate. They are fed by one-cycle error pulses from the receiver. Every output is registered, so each result appears on the clock edge after the input that caused it.

Top module: `mdrop_filter`

## Requirements
- R1: After reset, `out_valid`, `msg_end` and `msg_cause` are 0, all four counters read 0, and the block is asleep.
- R2: With `cfg_multidrop` low, every character that does not match a control entry appears one cycle later on `out_data`/`out_addr` with the same data and address flag, whatever the sleep state.
- R3: With `cfg_multidrop` high and `cfg_wake_idle` low, characters are dropped while asleep. The exception is an address-flagged character equal to `cfg_addr0` or `cfg_addr1`, which wakes the block and is output with `out_addr` = 1.
- R4: While awake, an address-flagged character matching neither address is dropped and puts the block to sleep. Later non-address characters are then dropped, and idle pulses do not wake it in address wake mode.
- R5: With `cfg_multidrop` and `cfg_wake_idle` high, every character, address or not, is dropped while asleep, and one `in_idle` pulse wakes the block.
- R6: Control entry i (data at bits 8i+7:8i of `cfg_ctl_char`) takes part only if `cfg_ctl_valid[i]` is set. When several entries match, the lowest index wins. A match with its reject bit clear outputs the character and raises `msg_end` with cause 2 in the same cycle.
- R7: A control match whose `cfg_ctl_reject[i]` bit is set raises `msg_end` with cause 2 and does not output the character.
- R8: While a message is open, `msg_end` rises with cause 1 on the `cfg_idle_max`-th consecutive idle pulse. Any received character restarts the count, and a `cfg_idle_max` of 0 disables the timeout.
- R9: When an address-flagged character is handled while a message is open (awake, multidrop on), `msg_end` rises with cause 3, whether the address matches or not.
- R10: Counter index 0 (`cnt_parity`), 1 (`cnt_frame`), 2 (`cnt_noise`) and 3 (`cnt_break`) each add one per cycle in which its error input is high, and each holds at 0xFFFF.
- R11: `cnt_clear[k]` zeroes counter k on the next edge and takes priority over a simultaneous error pulse.
- R12: `msg_end` is a one-cycle strobe per closing event, and `msg_cause` is 0 whenever `msg_end` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_multidrop | input | 1 | Enable sleep/wake filtering |
| cfg_wake_idle | input | 1 | 1: idle wake, 0: address wake |
| cfg_addr0 | input | 8 | First station address |
| cfg_addr1 | input | 8 | Second station address |
| cfg_ctl_char | input | 64 | Eight control characters, entry i at bits 8i+7:8i |
| cfg_ctl_valid | input | 8 | Per-entry enable |
| cfg_ctl_reject | input | 8 | Per-entry discard-on-match |
| cfg_idle_max | input | 16 | Idle pulses that close a message, 0 = off |
| in_valid | input | 1 | Received character strobe |
| in_data | input | 8 | Received character |
| in_addr | input | 1 | Character carries the address bit |
| in_idle | input | 1 | One idle character time elapsed |
| err_parity | input | 1 | Parity/CRC error pulse |
| err_frame | input | 1 | Framing error pulse |
| err_noise | input | 1 | Noise error pulse |
| err_break | input | 1 | Break pulse |
| cnt_clear | input | 4 | Per-counter clear strobe |
| out_valid | output | 1 | Filtered character strobe |
| out_data | output | 8 | Filtered character |
| out_addr | output | 1 | Filtered character was an address |
| msg_end | output | 1 | Message closed |
| msg_cause | output | 2 | 1 idle, 2 control, 3 address, 0 none |
| cnt_parity | output | 16 | Parity/CRC error count |
| cnt_frame | output | 16 | Framing error count |
| cnt_noise | output | 16 | Noise error count |
| cnt_break | output | 16 | Break count |

## Verification
A sleep flag that is wrongly set shows on the next character. That character is either output when it should have been dropped, or missing when it should have been output, one cycle after it arrives. A stale message-open flag shows up in two ways. It can produce a closing strobe that should not be there, or it can miss one, on the next address character or on the idle pulse that reaches the limit. An idle count that drifts moves the timeout strobe by whole idle periods. Since the reference model is compared on every clock, each of these faults is caught within one cycle of its first visible effect.

// File: rtl/mdrop_filter.sv
module mdrop_filter #(
  parameter int DW   = 8,
  parameter int NCTL = 8,
  parameter int CW   = 16,
  parameter int TW   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_multidrop,
  input  logic             cfg_wake_idle,
  input  logic [DW-1:0]    cfg_addr0,
  input  logic [DW-1:0]    cfg_addr1,
  input  logic [NCTL*DW-1:0] cfg_ctl_char,
  input  logic [NCTL-1:0]  cfg_ctl_valid,
  input  logic [NCTL-1:0]  cfg_ctl_reject,
  input  logic [TW-1:0]    cfg_idle_max,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             in_addr,
  input  logic             in_idle,
  input  logic             err_parity,
  input  logic             err_frame,
  input  logic             err_noise,
  input  logic             err_break,
  input  logic [3:0]       cnt_clear,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_addr,
  output logic             msg_end,
  output logic [1:0]       msg_cause,
  output logic [CW-1:0]    cnt_parity,
  output logic [CW-1:0]    cnt_frame,
  output logic [CW-1:0]    cnt_noise,
  output logic [CW-1:0]    cnt_break
);
  localparam logic [1:0] CAUSE_IDLE = 2'd1;
  localparam logic [1:0] CAUSE_CTL  = 2'd2;
  localparam logic [1:0] CAUSE_ADDR = 2'd3;
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  logic          asleep, open_q;
  logic [TW-1:0] idle_cnt;
  logic          hit, hit_rej;

  always_comb begin
    hit = 1'b0;
    hit_rej = 1'b0;
    for (int i = NCTL-1; i >= 0; i--) begin
      if (cfg_ctl_valid[i] && cfg_ctl_char[i*DW +: DW] == in_data) begin
        hit = 1'b1;
        hit_rej = cfg_ctl_reject[i];
      end
    end
  end

  wire addr_hit  = (in_data == cfg_addr0) || (in_data == cfg_addr1);
  wire live      = !cfg_multidrop || !asleep;
  wire addr_path = cfg_multidrop && in_addr && !(asleep && cfg_wake_idle);
  wire [TW-1:0] idle_next = idle_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep    <= 1'b1;
      open_q    <= 1'b0;
      idle_cnt  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= 1'b0;
      msg_end   <= 1'b0;
      msg_cause <= 2'd0;
    end else begin
      out_valid <= 1'b0;
      msg_end   <= 1'b0;
      msg_cause <= 2'd0;
      if (in_valid) begin
        idle_cnt <= '0;
        out_data <= in_data;
        out_addr <= in_addr;
        if (addr_path) begin
          if (open_q) begin
            msg_end   <= 1'b1;
            msg_cause <= CAUSE_ADDR;
          end
          asleep    <= !addr_hit;
          out_valid <= addr_hit;
          open_q    <= addr_hit;
        end else if (live) begin
          if (hit) begin
            msg_end   <= 1'b1;
            msg_cause <= CAUSE_CTL;
            out_valid <= !hit_rej;
            open_q    <= 1'b0;
          end else begin
            out_valid <= 1'b1;
            open_q    <= 1'b1;
          end
        end
      end else if (in_idle) begin
        if (cfg_multidrop && asleep && cfg_wake_idle) begin
          asleep <= 1'b0;
        end else if (live && open_q && cfg_idle_max != '0) begin
          if (idle_next == cfg_idle_max) begin
            msg_end   <= 1'b1;
            msg_cause <= CAUSE_IDLE;
            open_q    <= 1'b0;
            idle_cnt  <= '0;
          end else begin
            idle_cnt <= idle_next;
          end
        end
      end
    end
  end

  wire [3:0] ev = {err_break, err_noise, err_frame, err_parity};
  logic [CW-1:0] cnt_q [4];

  for (genvar k = 0; k < 4; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n || cnt_clear[k]) cnt_q[k] <= '0;
      else if (ev[k] && cnt_q[k] != CNT_TOP) cnt_q[k] <= cnt_q[k] + 1'b1;
    end
  end

  assign cnt_parity = cnt_q[0];
  assign cnt_frame  = cnt_q[1];
  assign cnt_noise  = cnt_q[2];
  assign cnt_break  = cnt_q[3];
endmodule

// File: rtl/mdrop_filter_chk.sv
module mdrop_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        err_parity,
  input logic        err_break,
  input logic [3:0]  cnt_clear,
  input logic        out_valid,
  input logic        msg_end,
  input logic [1:0]  msg_cause,
  input logic [15:0] cnt_parity,
  input logic [15:0] cnt_break
);
  AST_CAUSE_WITH_END: assert property (@(posedge clk) disable iff (!rst_n) msg_end |-> msg_cause != 2'd0); // R12
  AST_CAUSE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !msg_end |-> msg_cause == 2'd0); // R12
  AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n) in_valid == 1'b0 |=> !out_valid); // R2
  AST_BREAK_SATURATES: assert property (@(posedge clk) disable iff (!rst_n) (cnt_break == 16'hFFFF && !cnt_clear[3]) |=> cnt_break == 16'hFFFF); // R10
  AST_PARITY_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!cnt_clear[0] && !err_parity) |=> $stable(cnt_parity)); // R10
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) cnt_clear[0] |=> cnt_parity == 16'h0000); // R11
  AST_BREAK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (cnt_clear[3] && err_break) |=> cnt_break == 16'h0000); // R11
endmodule

bind mdrop_filter mdrop_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .err_parity(err_parity),
  .err_break(err_break), .cnt_clear(cnt_clear), .out_valid(out_valid),
  .msg_end(msg_end), .msg_cause(msg_cause), .cnt_parity(cnt_parity),
  .cnt_break(cnt_break)
);

// File: tb/test_mdrop_filter.sv
`timescale 1ns/1ps
module test_mdrop_filter;
  logic clk = 0, rst_n = 0;
  logic cfg_multidrop = 0, cfg_wake_idle = 0;
  logic [7:0] cfg_addr0 = 8'h21, cfg_addr1 = 8'h35;
  logic [63:0] cfg_ctl_char = '0;
  logic [7:0] cfg_ctl_valid = '0, cfg_ctl_reject = '0;
  logic [15:0] cfg_idle_max = 16'd3;
  logic in_valid = 0, in_addr = 0, in_idle = 0;
  logic [7:0] in_data = 0;
  logic err_parity = 0, err_frame = 0, err_noise = 0, err_break = 0;
  logic [3:0] cnt_clear = 0;
  logic out_valid, out_addr, msg_end;
  logic [7:0] out_data;
  logic [1:0] msg_cause;
  logic [15:0] cnt_parity, cnt_frame, cnt_noise, cnt_break;

  mdrop_filter i_mdrop_filter (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  bit m_sleep = 1, m_open = 0;
  int m_idle = 0;
  int m_cnt [4] = '{0, 0, 0, 0};
  bit e_valid, e_addr, e_end;
  int e_data, e_cause;

  task automatic model_char();
    int hit = -1;
    for (int i = 7; i >= 0; i--)
      if (cfg_ctl_valid[i] && cfg_ctl_char[i*8 +: 8] == in_data) hit = i;
    e_data = in_data; e_addr = in_addr;
    if (hit >= 0) begin
      e_end = 1; e_cause = 2; e_valid = !cfg_ctl_reject[hit]; m_open = 0;
    end else begin
      e_valid = 1; m_open = 1;
    end
  endtask

  task automatic cyc(string tag);
    int ev [4];
    e_valid = 0; e_end = 0; e_cause = 0; e_addr = 0; e_data = 0;
    ev = '{int'(err_parity), int'(err_frame), int'(err_noise), int'(err_break)};
    if (in_valid) begin
      m_idle = 0;
      if (!cfg_multidrop) model_char();
      else if (in_addr && !(m_sleep && cfg_wake_idle)) begin
        bit match = (in_data == cfg_addr0) || (in_data == cfg_addr1);
        if (m_open) begin e_end = 1; e_cause = 3; end
        m_sleep = !match; m_open = match;
        e_valid = match; e_data = in_data; e_addr = 1;
      end else if (!m_sleep) model_char();
    end else if (in_idle) begin
      if (cfg_multidrop && m_sleep && cfg_wake_idle) m_sleep = 0;
      else if ((!cfg_multidrop || !m_sleep) && m_open && cfg_idle_max != 0) begin
        m_idle++;
        if (m_idle == cfg_idle_max) begin
          e_end = 1; e_cause = 1; m_open = 0; m_idle = 0;
        end
      end
    end
    for (int k = 0; k < 4; k++) begin
      if (cnt_clear[k]) m_cnt[k] = 0;
      else if (ev[k] != 0 && m_cnt[k] < 65535) m_cnt[k]++;
    end
    @(posedge clk); #1;
    checks++;
    if (out_valid !== e_valid || msg_end !== e_end || msg_cause !== 2'(e_cause) ||
        (e_valid && (out_data !== 8'(e_data) || out_addr !== e_addr))) begin
      errors++;
      $display("FAIL %s: valid=%0d data=%h addr=%0d end=%0d cause=%0d expected valid=%0d data=%h addr=%0d end=%0d cause=%0d",
               tag, out_valid, out_data, out_addr, msg_end, msg_cause, e_valid, e_data, e_addr, e_end, e_cause);
    end
    checks++;
    if (cnt_parity !== 16'(m_cnt[0]) || cnt_frame !== 16'(m_cnt[1]) ||
        cnt_noise !== 16'(m_cnt[2]) || cnt_break !== 16'(m_cnt[3])) begin
      errors++;
      $display("FAIL %s: counters=%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d", tag,
               cnt_parity, cnt_frame, cnt_noise, cnt_break, m_cnt[0], m_cnt[1], m_cnt[2], m_cnt[3]);
    end
  endtask

  task automatic chr(logic [7:0] d, logic a, string tag);
    in_valid = 1; in_data = d; in_addr = a;
    cyc(tag);
    in_valid = 0; in_addr = 0;
  endtask

  task automatic idl(int n, string tag);
    for (int i = 0; i < n; i++) begin
      in_idle = 1; cyc(tag); in_idle = 0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    cfg_ctl_char[0*8 +: 8] = 8'h0D; cfg_ctl_valid[0] = 1;
    cfg_ctl_char[2*8 +: 8] = 8'h1B; cfg_ctl_valid[2] = 1; cfg_ctl_reject[2] = 1;
    cfg_ctl_char[5*8 +: 8] = 8'h0D; cfg_ctl_valid[5] = 1; cfg_ctl_reject[5] = 1;
    cfg_ctl_char[3*8 +: 8] = 8'h41;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 0 || msg_end !== 0 || msg_cause !== 0 || cnt_parity !== 0 ||
        cnt_frame !== 0 || cnt_noise !== 0 || cnt_break !== 0) begin
      errors++;
      $display("FAIL R1: reset outputs valid=%0d end=%0d cause=%0d expected all 0", out_valid, msg_end, msg_cause);
    end
    @(negedge clk); rst_n = 1;
    cyc("R1");
    // pass-through, multidrop off
    chr(8'h10, 0, "R2"); chr(8'h41, 0, "R2"); chr(8'h7F, 1, "R2");
    // control match store and reject
    chr(8'h0D, 0, "R6");
    chr(8'h55, 0, "R7"); chr(8'h1B, 0, "R7"); cyc("R12");
    // idle timeout
    chr(8'h60, 0, "R8"); idl(2, "R8"); chr(8'h61, 0, "R8"); idl(3, "R8"); idl(2, "R8");
    cfg_idle_max = 0; chr(8'h62, 0, "R8"); idl(5, "R8"); cfg_idle_max = 3;
    chr(8'h0D, 0, "R6");
    // address wake
    cfg_multidrop = 1;
    chr(8'h12, 0, "R3"); chr(8'h40, 1, "R3"); idl(2, "R3");
    chr(8'h35, 1, "R3"); chr(8'h12, 0, "R3");
    chr(8'h21, 1, "R9"); chr(8'h13, 0, "R9");
    chr(8'h77, 1, "R4"); chr(8'h14, 0, "R4"); idl(2, "R4"); chr(8'h15, 0, "R4");
    chr(8'h21, 1, "R3"); chr(8'h16, 0, "R3"); idl(3, "R8");
    chr(8'h40, 1, "R4");
    // idle wake
    cfg_wake_idle = 1;
    chr(8'h17, 0, "R5"); chr(8'h21, 1, "R5"); idl(1, "R5");
    chr(8'h18, 0, "R5"); chr(8'h1B, 0, "R7");
    chr(8'h19, 0, "R5"); chr(8'h40, 1, "R9"); chr(8'h1A, 0, "R5");
    cfg_multidrop = 0; cfg_wake_idle = 0;
    chr(8'h1C, 0, "R2");
    // error counters
    for (int i = 0; i < 40; i++) begin
      err_parity = (i % 2) == 0; err_frame = (i % 3) == 0;
      err_noise = (i % 5) == 1; err_break = (i % 7) < 3;
      cyc("R10");
    end
    err_parity = 1; err_break = 1; cnt_clear = 4'b1001; cyc("R11");
    cnt_clear = 4'b0110; cyc("R11");
    cnt_clear = 0; err_parity = 0; err_frame = 0; err_noise = 0;
    for (int i = 0; i < 65540; i++) cyc("R10");
    err_break = 0; cyc("R10");
    cnt_clear = 4'b1000; cyc("R11"); cnt_clear = 0; cyc("R11");
    finish_run();
  end
endmodule